// File: doc/BRIEF.md
# Frequency-change recovery watchdog

This block owns the active output-frequency code of a clock generator and guards every software frequency change with a timer. Software writes frequency codes and a watchdog control byte through a plain register write port. If a nonzero timeout code is already in place when a frequency change is written, the timer starts. Software that survives the change acknowledges it by writing a zero timeout code. If that does not happen, the block assumes the system has hung.

On the first timeout the block drives an active-low system reset pulse, raises an alarm flag and restarts the timer. It leaves the frequency alone. On the second timeout and on every later one, it pulses reset again and also falls back to a safe frequency. The safe frequency is either the strapped hardware code or the software code that was active before the latest change. The timer keeps re-arming until the timeout code is cleared. The timer advances only on a prescaled tick input.

Top module: `freq_recovery_wd`

## Requirements
- R1: While reset is asserted and just after it, `freq_code` equals `strap_code`, `alarm` is 0 and `sys_rst_n` is 1.
- R2: A write to address 0 sets `freq_code` to `wr_data[7:0]` from the next cycle. Address 1 stores `wr_data[3:0]` as a staged half and changes nothing visible. A write to address 2 sets `freq_code` to `{wr_data[3:0], staged[3:0]}`.
- R3: Address 3 is the control byte. Its bits are: [3:0] timeout code, [6] fallback select, [7] reset-pulse enable. A frequency write arms the timer only if the stored timeout code is already nonzero. Without arming, no reset pulse occurs and `alarm` stays 0, although the frequency still changes.
- R4: After an arming write, an expiry happens on the (code × TICKS_PER_UNIT)-th `tick` that arrives after the write cycle. A tick in the write cycle itself does not count. After each expiry the timer reloads from the current code.
- R5: On the first expiry, `alarm` becomes 1 and `freq_code` is unchanged. If bit 7 is 1, `sys_rst_n` is low for exactly PULSE_CYCLES cycles, starting the cycle after the expiry. If bit 7 is 0, no pulse is sent.
- R6: On the second and every later expiry, the pulse and alarm behave as in R5. In addition, `freq_code` becomes `strap_code` as sampled at that expiry when bit 6 is 0. When bit 6 is 1, it becomes the code that was active before the latest software change.
- R7: A control write with bits [3:0] = 0 stops the timer and clears `alarm` from the next cycle. `freq_code` keeps its value and no further pulses start.
- R8: A frequency write while the timer runs restarts the full timeout period and resets the expiry count. The next expiry therefore counts as a first expiry.
- R9: A clear write or a frequency write in the cycle of a due expiry wins. No pulse starts, and R7 or R8 applies instead.
- R10: Bit 4 of a control write is ignored, so such a write never sets `alarm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| tick | input | 1 | Prescaled timer tick, one cycle wide |
| strap_code | input | 8 | Hardware-strapped frequency code |
| freq_code | output | 8 | Active frequency code |
| sys_rst_n | output | 1 | Active-low system reset pulse |
| alarm | output | 1 | Watchdog alarm status |

## Verification
Two functions can fall in the same cycle: a timer expiry and a software write, either a clear of the timeout code or a new frequency. The bench provokes this by holding `tick` high, so that the expiry cycle is known exactly. It then issues the write on that exact edge. It judges the outcome by seeing no reset pulse and by the timing of the following expiry. Random traffic also produces such collisions, and these are compared against a cycle model in the bench.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int unsigned CODE_W  = 4;
  localparam logic [1:0]  A_FREQ  = 2'd0;
  localparam logic [1:0]  A_STAGE = 2'd1;
  localparam logic [1:0]  A_EXTHI = 2'd2;
  localparam logic [1:0]  A_CTL   = 2'd3;
  localparam int unsigned B_FBSEL = 6;
  localparam int unsigned B_RSTEN = 7;

  // timeout length in ticks for a timeout code
  function automatic int unsigned load_ticks(input logic [CODE_W-1:0] code,
                                             input int unsigned tpu);
    return int'(code) * tpu;
  endfunction
endpackage

// File: rtl/fwd_regs.sv
module fwd_regs #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned FREQ_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [1:0]                 wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [fwd_pkg::CODE_W-1:0] code,
  output logic                       fb_sel,
  output logic                       rst_en,
  output logic                       freq_wr,
  output logic [FREQ_W-1:0]          freq_new,
  output logic                       clear_wr
);
  import fwd_pkg::*;
  localparam int unsigned HALF = FREQ_W / 2;
  localparam int unsigned HIGH = FREQ_W - HALF;

  logic [HALF-1:0] stage_q;
  logic            ctl_wr;
  logic            single_wr;
  logic            ext_wr;
  logic            ctl_unused;

  assign ctl_unused = ^wr_data[5:4];
  assign single_wr  = wr_en && (wr_addr == A_FREQ);
  assign ext_wr     = wr_en && (wr_addr == A_EXTHI);
  assign ctl_wr     = wr_en && (wr_addr == A_CTL);
  assign freq_wr    = single_wr || ext_wr;
  assign clear_wr   = ctl_wr && (wr_data[CODE_W-1:0] == '0);
  assign freq_new   = ext_wr ? {wr_data[HIGH-1:0], stage_q}
                             : wr_data[FREQ_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code    <= '0;
      fb_sel  <= 1'b0;
      rst_en  <= 1'b0;
      stage_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_CTL) begin
        code   <= wr_data[CODE_W-1:0];
        fb_sel <= wr_data[B_FBSEL];
        rst_en <= wr_data[B_RSTEN];
      end
      if (wr_addr == A_STAGE) stage_q <= wr_data[HALF-1:0];
    end
  end
endmodule

// File: rtl/fwd_timer.sv
module fwd_timer #(
  parameter int unsigned TICKS_PER_UNIT = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       arm,
  input  logic                       stop,
  input  logic                       hold,
  input  logic [fwd_pkg::CODE_W-1:0] code,
  output logic                       expire,
  output logic                       running,
  output logic                       repeat_exp
);
  import fwd_pkg::*;
  localparam int unsigned MAXT  = ((1 << CODE_W) - 1) * TICKS_PER_UNIT;
  localparam int unsigned CNT_W = $clog2(MAXT + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload;

  assign reload = CNT_W'(load_ticks(code, TICKS_PER_UNIT));
  assign expire = tick && running && (cnt_q == CNT_W'(1)) && !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      running    <= 1'b0;
      repeat_exp <= 1'b0;
    end else if (arm) begin
      cnt_q      <= reload;
      running    <= 1'b1;
      repeat_exp <= 1'b0;
    end else if (stop) begin
      running    <= 1'b0;
      repeat_exp <= 1'b0;
    end else if (expire) begin
      cnt_q      <= reload;
      repeat_exp <= 1'b1;
    end else if (tick && running) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/fwd_pulse.sv
module fwd_pulse #(
  parameter int unsigned PULSE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse_n
);
  localparam int unsigned PW = $clog2(PULSE_CYCLES + 1);
  logic [PW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 left_q <= '0;
    else if (fire)              left_q <= PW'(PULSE_CYCLES);
    else if (left_q != '0)      left_q <= left_q - PW'(1);
  end

  assign pulse_n = (left_q == '0);
endmodule

// File: rtl/freq_recovery_wd.sv
module freq_recovery_wd #(
  parameter int unsigned DATA_W         = 8,
  parameter int unsigned FREQ_W         = 8,
  parameter int unsigned TICKS_PER_UNIT = 4,
  parameter int unsigned PULSE_CYCLES   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tick,
  input  logic [FREQ_W-1:0] strap_code,
  output logic [FREQ_W-1:0] freq_code,
  output logic              sys_rst_n,
  output logic              alarm
);
  import fwd_pkg::*;

  logic [CODE_W-1:0] code;
  logic              fb_sel;
  logic              rst_en;
  logic              freq_wr;
  logic [FREQ_W-1:0] freq_new;
  logic              clear_wr;
  logic              wd_arm;
  logic              wd_expire;
  logic              wd_running;
  logic              wd_repeat;
  logic              pulse_fire;
  logic [FREQ_W-1:0] prev_code;
  logic [FREQ_W-1:0] fallback;

  fwd_regs #(.DATA_W(DATA_W), .FREQ_W(FREQ_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .code(code), .fb_sel(fb_sel), .rst_en(rst_en),
    .freq_wr(freq_wr), .freq_new(freq_new), .clear_wr(clear_wr)
  );

  assign wd_arm = freq_wr && (code != '0);

  fwd_timer #(.TICKS_PER_UNIT(TICKS_PER_UNIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .arm(wd_arm), .stop(clear_wr),
    .hold(freq_wr || clear_wr), .code(code), .expire(wd_expire),
    .running(wd_running), .repeat_exp(wd_repeat)
  );

  assign pulse_fire = wd_expire && rst_en;

  fwd_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(pulse_fire), .pulse_n(sys_rst_n)
  );

  assign fallback = fb_sel ? prev_code : strap_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_code <= strap_code;
      prev_code <= strap_code;
    end else if (freq_wr) begin
      prev_code <= freq_code;
      freq_code <= freq_new;
    end else if (wd_expire && wd_repeat) begin
      freq_code <= fallback;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         alarm <= 1'b0;
    else if (clear_wr)  alarm <= 1'b0;
    else if (wd_expire) alarm <= 1'b1;
  end
endmodule

// File: rtl/fwd_checker.sv
module fwd_checker #(
  parameter int unsigned FREQ_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wd_expire,
  input logic              wd_running,
  input logic              wd_repeat,
  input logic              rst_en,
  input logic              clear_wr,
  input logic              freq_wr,
  input logic [FREQ_W-1:0] freq_code,
  input logic              sys_rst_n,
  input logic              alarm
);
  AST_ALARM_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> alarm); // R5
  AST_CLEAR_DROPS_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
    clear_wr |=> (!alarm && !wd_running)); // R7
  AST_FIRST_KEEPS_FREQ: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_expire && !wd_repeat && !freq_wr) |=> $stable(freq_code)); // R5
  AST_PULSE_FROM_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_n) |-> $past(wd_expire)); // R5
  AST_IDLE_NO_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_running |-> !wd_expire); // R3
  AST_DISABLED_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_en && sys_rst_n) |=> sys_rst_n); // R5
  AST_WRITE_BEATS_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_wr && sys_rst_n) |=> sys_rst_n); // R9
endmodule

bind freq_recovery_wd fwd_checker #(.FREQ_W(FREQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wd_expire(wd_expire), .wd_running(wd_running),
  .wd_repeat(wd_repeat), .rst_en(rst_en), .clear_wr(clear_wr),
  .freq_wr(freq_wr), .freq_code(freq_code), .sys_rst_n(sys_rst_n),
  .alarm(alarm)
);

// File: tb/freq_recovery_wd_tb.sv
module freq_recovery_wd_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TPU = 4;
  localparam int PW  = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tick = 1'b0;
  logic [7:0] strap_code = 8'h3C;
  logic [7:0] freq_code;
  logic       sys_rst_n;
  logic       alarm;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  freq_recovery_wd u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tick(tick), .strap_code(strap_code),
    .freq_code(freq_code), .sys_rst_n(sys_rst_n), .alarm(alarm)
  );

  // ---------------- cycle model ----------------
  logic [7:0] m_freq, m_prev;
  logic [3:0] m_code, m_stage;
  logic       m_sel, m_en, m_alarm, m_run, m_second;
  int         m_seen, m_lim, m_pulse;

  function automatic int limit_of(input logic [3:0] c);
    return TPU * c;
  endfunction

  always @(posedge clk) begin
    logic fw, clr, ctw, due;
    logic [7:0] nf;
    if (!rst_n) begin
      m_freq = strap_code; m_prev = strap_code; m_code = 0; m_stage = 0;
      m_sel = 0; m_en = 0; m_alarm = 0; m_run = 0; m_second = 0;
      m_seen = 0; m_lim = 0; m_pulse = 0;
    end else begin
      fw  = wr_en && (wr_addr == 2'd0 || wr_addr == 2'd2);
      ctw = wr_en && wr_addr == 2'd3;
      clr = ctw && wr_data[3:0] == 4'd0;
      nf  = (wr_addr == 2'd2) ? {wr_data[3:0], m_stage} : wr_data;
      due = tick && m_run && (m_seen + 1 == m_lim) && !fw && !clr;
      if (m_pulse > 0) m_pulse = m_pulse - 1;
      if (due && m_en) m_pulse = PW;
      if (fw) begin
        m_prev = m_freq; m_freq = nf;
        if (m_code != 0) begin
          m_run = 1; m_seen = 0; m_lim = limit_of(m_code); m_second = 0;
        end
      end else if (clr) begin
        m_run = 0; m_alarm = 0; m_second = 0;
      end else if (due) begin
        m_alarm = 1; m_seen = 0; m_lim = limit_of(m_code);
        if (m_second) m_freq = m_sel ? m_prev : strap_code;
        m_second = 1;
      end else if (tick && m_run) begin
        m_seen = m_seen + 1;
      end
      if (ctw) begin
        m_code = wr_data[3:0]; m_sel = wr_data[6]; m_en = wr_data[7];
      end
      if (wr_en && wr_addr == 2'd1) m_stage = wr_data[3:0];
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      tests++;
      if (freq_code !== m_freq) begin
        fails++;
        $display("FAIL R6 model freq: actual %h expected %h", freq_code, m_freq);
      end
      if (alarm !== m_alarm) begin
        fails++;
        $display("FAIL R5 model alarm: actual %b expected %b", alarm, m_alarm);
      end
      if (sys_rst_n !== (m_pulse == 0)) begin
        fails++;
        $display("FAIL R9 model reset: actual %b expected %b", sys_rst_n, m_pulse == 0);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_low(output int k);
    k = 0;
    while (sys_rst_n && k < 200) begin @(negedge clk); k++; end
  endtask

  task automatic wait_high();
    int g = 0;
    while (!sys_rst_n && g < 200) begin @(negedge clk); g++; end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic no_pulse(input int n, input string tag);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (!sys_rst_n) seen = 1; end
    chk(!seen, tag, seen, 0);
  endtask

  initial begin
    int k, w;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(freq_code == 8'h3C && alarm == 0 && sys_rst_n == 1, "R1 reset state",
        {freq_code, alarm, sys_rst_n}, {8'h3C, 1'b0, 1'b1});
    rst_n = 1;
    @(negedge clk);
    chk(freq_code == 8'h3C, "R1 after release", freq_code, 8'h3C);

    wr(2'd0, 8'hA5);
    chk(freq_code == 8'hA5, "R2 single write", freq_code, 8'hA5);
    wr(2'd1, 8'h07);
    chk(freq_code == 8'hA5, "R2 stage alone", freq_code, 8'hA5);
    wr(2'd2, 8'h0B);
    chk(freq_code == 8'hB7, "R2 pair commit", freq_code, 8'hB7);

    tick = 1;
    no_pulse(100, "R3 unarmed no pulse");
    chk(alarm == 0, "R3 unarmed alarm", alarm, 0);

    wr(2'd3, 8'h82);
    wr(2'd0, 8'h11);
    wait_low(k);
    chk(k == 8, "R4 timeout ticks", k, 8);
    chk(freq_code == 8'h11, "R5 first keeps freq", freq_code, 8'h11);
    chk(alarm == 1, "R5 alarm set", alarm, 1);
    w = 0;
    while (!sys_rst_n && w < 50) begin w++; @(negedge clk); end
    chk(w == PW, "R5 pulse width", w, PW);

    wait_low(k);
    chk(freq_code == 8'h3C, "R6 strap fallback", freq_code, 8'h3C);
    strap_code = 8'h44;
    wait_high();
    wait_low(k);
    chk(freq_code == 8'h44, "R6 strap relatched", freq_code, 8'h44);
    chk(k == 4, "R6 repeat period", k, 4);

    wr(2'd3, 8'h00);
    chk(alarm == 0, "R7 clear alarm", alarm, 0);
    idle(6);
    no_pulse(80, "R7 stopped");
    chk(freq_code == 8'h44, "R7 freq kept", freq_code, 8'h44);

    wr(2'd3, 8'hC2);
    wr(2'd0, 8'h66);
    wait_low(k);
    chk(freq_code == 8'h66, "R6 sel1 first", freq_code, 8'h66);
    wait_high();
    wait_low(k);
    chk(freq_code == 8'h44, "R6 previous code fallback", freq_code, 8'h44);

    wait_high();
    idle(1);
    wr(2'd0, 8'h77);
    wait_low(k);
    chk(k == 8, "R8 restart period", k, 8);
    chk(freq_code == 8'h77, "R8 counted as first", freq_code, 8'h77);
    wait_high();

    wr(2'd3, 8'h00);
    wr(2'd3, 8'h82);
    wr(2'd0, 8'h21);
    idle(7);
    wr(2'd3, 8'h00);
    no_pulse(30, "R9 clear beats expiry");
    chk(alarm == 0, "R9 clear alarm", alarm, 0);

    wr(2'd3, 8'h82);
    wr(2'd0, 8'h21);
    idle(7);
    wr(2'd0, 8'h22);
    wait_low(k);
    chk(k == 8, "R9 freq write beats expiry", k, 8);
    chk(freq_code == 8'h22, "R9 restarted first", freq_code, 8'h22);
    wait_high();

    wr(2'd3, 8'h00);
    wr(2'd3, 8'h13);
    idle(2);
    chk(alarm == 0, "R10 bit4 ignored", alarm, 0);

    wr(2'd3, 8'h02);
    wr(2'd0, 8'h55);
    wait_low(k);
    chk(k == 200 && alarm == 1, "R5 disabled pulse", sys_rst_n, 1);
    wr(2'd3, 8'h00);

    for (int c = 0; c < 6000; c++) begin
      tick = ($urandom % 2) == 0;
      if (($urandom % 7) == 0) begin
        logic [7:0] d = 8'($urandom);
        logic [1:0] a = 2'($urandom);
        if (a == 2'd3) d[3:0] = (($urandom % 4) == 0) ? 4'd0 : 4'(1 + $urandom % 3);
        if (($urandom % 50) == 0) strap_code = 8'($urandom);
        wr_en = 1; wr_addr = a; wr_data = d;
      end else begin
        wr_en = 0;
      end
      @(negedge clk);
    end
    wr_en = 0;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog expired: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule